// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides a WIDTH-bit dividend by a WIDTH-bit divisor one quotient bit per clock, using the restoring method. A single working register carries both values: its upper field holds the partial remainder and its lower field receives each new quotient bit as the register moves left. The register is shifted once when an operation starts. Each later step subtracts the divisor from the upper field and keeps the difference or restores the old value, according to the sign. When the last bit is in, the upper field sits one place too far left, and a one-bit right shift of that field gives the true remainder.

A caller pulses `start` with the operands and a mode bit. The block raises `busy`, works for WIDTH cycles, then pulses `done` once and holds the quotient, remainder and divide-by-zero flag until the next operation is accepted. When `signed_op` is set, the operands are turned into magnitudes before the core runs. The quotient is negated when the operand signs differ, and the remainder takes the dividend's sign. The upper field carries one guard bit and the trial subtraction is one bit wider still, so the borrow always marks a negative difference, even when the divisor is close to full scale.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `quotient`, `remainder` and `div_by_zero` are all 0.
- R2: A `start` sampled at a rising edge while `busy` is 0 is accepted, and `busy` is 1 after that edge. This includes the edge at which `done` is 1.
- R3: `done` is 1 for exactly one cycle, after the WIDTH-th rising edge that follows the edge that accepted `start`. `busy` falls at that same edge.
- R4: In unsigned mode (`signed_op` = 0) with a nonzero divisor, `quotient` = floor(dividend/divisor) and `remainder` = dividend − quotient·divisor < divisor, with both operands read as unsigned even when their top bit is set. For example, 73/5 gives 14 remainder 3, 200/7 gives 28 remainder 4, and 255/255 gives 1 remainder 0.
- R5: A `start` while `busy` is 1 is ignored, and the running operation ends with the results of its own operands.
- R6: A zero divisor in either mode completes in the same time. It sets `div_by_zero` to 1, gives an all-ones `quotient`, and returns the dividend unchanged as `remainder`. Otherwise `div_by_zero` is 0.
- R7: In signed mode (`signed_op` = 1, two's complement) with a nonzero divisor, `quotient` is the true quotient truncated toward zero. It is negative when the operand signs differ, and the most negative dividend divided by −1 wraps to the most negative value.
- R8: In signed mode, `remainder` = dividend − quotient·divisor. It is zero or has the sign of the dividend, for example −7/2 gives −3 remainder −1 and 7/−2 gives −3 remainder 1.
- R9: `quotient`, `remainder` and `div_by_zero` stay unchanged from `done` until the next accepted `start`, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| start | input | 1 | Request to begin a division; sampled while not busy |
| signed_op | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, captured when start is accepted |
| divisor | input | WIDTH | Divisor, captured when start is accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | WIDTH | Quotient of the last completed operation |
| remainder | output | WIDTH | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
Completion and acceptance can meet in one cycle: a new `start` can arrive exactly when `done` is high, because the core has already returned to idle. The bench drives a fresh request at the negative edge where it first sees `done`. It then checks that `busy` is set and `done` is cleared one edge later, and that the second result matches its own operands rather than the first. The opposite case also gets a test: a `start` inside a running operation, where the first result must come out untouched at the normal time.

// File: rtl/rqdiv_pkg.sv
package rqdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rqdiv_magnitude.sv
// Converts an operand to its magnitude when signed mode is active.
module rqdiv_magnitude #(
  parameter int WIDTH          = 8,
  parameter bit SIGNED_SUPPORT = 1'b1
) (
  input  logic [WIDTH-1:0] value,
  input  logic             signed_en,
  output logic [WIDTH-1:0] magnitude,
  output logic             negative
);
  generate
    if (SIGNED_SUPPORT) begin : g_signed
      assign negative  = signed_en & value[WIDTH-1];
      assign magnitude = negative ? (~value + 1'b1) : value;
    end else begin : g_unsigned
      logic unused_mode;
      assign unused_mode = signed_en;
      assign negative    = 1'b0;
      assign magnitude   = value;
    end
  endgenerate
endmodule

// File: rtl/rqdiv_sign_fix.sv
// Applies result signs after the magnitude division.
module rqdiv_sign_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             neg_quo,
  input  logic             neg_rem,
  input  logic             zero_div,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  always_comb begin
    // a zero divisor keeps the all-ones quotient whatever the signs
    if (neg_quo && !zero_div) quotient = ~quo_mag + 1'b1;
    else                      quotient = quo_mag;
    if (neg_rem)              remainder = ~rem_mag + 1'b1;
    else                      remainder = rem_mag;
  end
endmodule

// File: rtl/rqdiv_core.sv
// Unsigned restoring divider; remainder and quotient share one register.
module rqdiv_core
  import rqdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem,
  output logic             zero_div
);
  localparam int RW = 2 * WIDTH + 1;       // guard bit + remainder field + quotient field
  localparam int HW = WIDTH + 1;           // upper (remainder) field width
  localparam int DW = WIDTH + 2;           // trial subtraction width
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] STEPS = CW'(WIDTH);

  run_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RW-1:0]    rq_q, rq_d;
  logic [WIDTH-1:0] dvs_q, dvs_d;
  logic             dbz_q, dbz_d;
  logic             done_q, done_d;

  logic [HW-1:0]    upper;
  logic [WIDTH-1:0] lower;
  logic [DW-1:0]    diff;
  logic             negative;
  logic             last_step;

  assign upper     = rq_q[RW-1:WIDTH];
  assign lower     = rq_q[WIDTH-1:0];
  assign diff      = {1'b0, upper} - {2'b00, dvs_q};
  assign negative  = diff[DW-1];
  assign busy      = (state_q == ST_RUN);
  assign accept    = start && !busy;
  assign last_step = (cnt_q == CW'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rq_d    = rq_q;
    dvs_d   = dvs_q;
    dbz_d   = dbz_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      cnt_d   = STEPS;
      rq_d    = {{WIDTH{1'b0}}, dividend, 1'b0};   // load, then first left shift
      dvs_d   = divisor;
      dbz_d   = (divisor == '0);
    end else if (busy) begin
      if (negative) rq_d = {rq_q[RW-2:0], 1'b0};                 // restore: keep old field
      else          rq_d = {diff[WIDTH-1:0], lower, 1'b1};       // keep difference
      cnt_d = cnt_q - 1'b1;
      if (last_step) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rq_q    <= '0;
      dvs_q   <= '0;
      dbz_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rq_q    <= rq_d;
      dvs_q   <= dvs_d;
      dbz_q   <= dbz_d;
      done_q  <= done_d;
    end
  end

  // final correction: upper field shifted back right by one
  assign quo      = lower;
  assign rem      = upper[HW-1:1];
  assign done     = done_q;
  assign zero_div = dbz_q;

  // run-length counter for the latency check
  logic [CW:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_len <= '0;
    else if (accept) chk_len <= '0;
    else if (busy)   chk_len <= chk_len + 1'b1;
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ends_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_len == (CW+1)'(WIDTH)));
  assert_diff_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !negative) |-> !diff[WIDTH]);
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zero_div) |-> (rem < dvs_q));
  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dvs_q));
  assert_zero_div_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_div) |-> (&quo));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import rqdiv_pkg::*;
#(
  parameter int WIDTH          = 8,
  parameter bit SIGNED_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             signed_op,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [WIDTH-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
  logic             dvd_neg, dvs_neg, accept;
  logic             neg_quo_q, neg_quo_d, neg_rem_q, neg_rem_d;

  rqdiv_magnitude #(.WIDTH(WIDTH), .SIGNED_SUPPORT(SIGNED_SUPPORT)) i_mag_dvd (
    .value(dividend), .signed_en(signed_op), .magnitude(dvd_mag), .negative(dvd_neg));
  rqdiv_magnitude #(.WIDTH(WIDTH), .SIGNED_SUPPORT(SIGNED_SUPPORT)) i_mag_dvs (
    .value(divisor), .signed_en(signed_op), .magnitude(dvs_mag), .negative(dvs_neg));

  rqdiv_core #(.WIDTH(WIDTH)) i_core (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .dividend(dvd_mag), .divisor(dvs_mag),
    .accept(accept), .busy(busy), .done(done),
    .quo(quo_mag), .rem(rem_mag), .zero_div(div_by_zero));

  // sign flags captured with the operands
  always_comb begin
    neg_quo_d = neg_quo_q;
    neg_rem_d = neg_rem_q;
    if (accept) begin
      neg_quo_d = dvd_neg ^ dvs_neg;
      neg_rem_d = dvd_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      neg_quo_q <= neg_quo_d;
      neg_rem_q <= neg_rem_d;
    end
  end

  rqdiv_sign_fix #(.WIDTH(WIDTH)) i_fix (
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .neg_quo(neg_quo_q), .neg_rem(neg_rem_q), .zero_div(div_by_zero),
    .quotient(quotient), .remainder(remainder));

  assert_quo_sign_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && neg_quo_q && !div_by_zero && (quotient != '0)) |-> quotient[WIDTH-1]);
  assert_rem_sign_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && neg_rem_q && (remainder != '0)) |-> remainder[WIDTH-1]);
  assert_results_held_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !$past(busy) && !$past(accept)) |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

// File: tb/test_restoring_divider.sv
`timescale 1ns/1ps
module test_restoring_divider;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         signed_op;
  logic [W-1:0] dividend, divisor;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  restoring_divider #(.WIDTH(W)) i_restoring_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected {div_by_zero, quotient, remainder}
  function automatic logic [2*W:0] model(input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
    int x, y, q, r;
    if (b == '0) return {1'b1, {W{1'b1}}, a};
    if (s) begin
      x = $signed(a);
      y = $signed(b);
    end else begin
      x = int'(a);
      y = int'(b);
    end
    q = x / y;
    r = x % y;
    return {1'b0, q[W-1:0], r[W-1:0]};
  endfunction

  task automatic wait_done(output int k);
    k = 1;
    while (!done && k < 1000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic check_result(input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W:0] e;
    string tq, tr;
    e  = model(s, a, b);
    tq = (b == '0) ? "R6" : (s ? "R7" : "R4");
    tr = (b == '0) ? "R6" : (s ? "R8" : "R4");
    check({tq, " quotient"}, 32'(quotient), 32'(e[2*W-1:W]));
    check({tr, " remainder"}, 32'(remainder), 32'(e[W-1:0]));
    check("R6 flag", 32'(div_by_zero), 32'(e[2*W]));
  endtask

  task automatic run_op(input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
    int k;
    @(negedge clk);
    start = 1'b1; signed_op = s; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    wait_done(k);
    check("R3 latency", 32'(k), 32'(W + 1));   // done seen after edge W following the accepting edge
    check("R3 busy low at done", 32'(busy), 32'd0);
    check_result(s, a, b);
    @(negedge clk);
    check("R3 done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    int k;
    logic [W-1:0] q_hold, r_hold;
    void'($urandom(32'h0005EED1));
    rst_n = 1'b0; start = 1'b0; signed_op = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 outputs in reset", 32'({quotient, remainder, div_by_zero}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 32'({busy, done, quotient, remainder, div_by_zero}), 32'd0);

    // directed corner cases
    run_op(1'b0, 8'd73, 8'd5);
    run_op(1'b0, 8'd200, 8'd7);
    run_op(1'b0, 8'd255, 8'd255);
    run_op(1'b0, 8'd255, 8'd1);
    run_op(1'b0, 8'd0, 8'd9);
    run_op(1'b0, 8'd3, 8'd200);
    run_op(1'b0, 8'd5, 8'd0);
    run_op(1'b1, 8'h80, 8'hFF);
    run_op(1'b1, 8'hF9, 8'd2);
    run_op(1'b1, 8'd7, 8'hFE);
    run_op(1'b1, 8'hCE, 8'd0);
    run_op(1'b1, 8'h80, 8'h80);

    // R5: start during a running operation is ignored
    @(negedge clk);
    start = 1'b1; signed_op = 1'b0; dividend = 8'd100; divisor = 8'd7;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; signed_op = 1'b1; dividend = 8'd5; divisor = 8'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done(k);
    check("R5 quotient unaffected", 32'(quotient), 32'd14);
    check("R5 remainder unaffected", 32'(remainder), 32'd2);

    // R2: new start in the cycle done is high
    start = 1'b1; signed_op = 1'b0; dividend = 8'd99; divisor = 8'd10;
    @(negedge clk);
    start = 1'b0;
    check("R2 accepted with done", 32'({busy, done}), 32'b10);
    wait_done(k);
    check("R2 back-to-back latency", 32'(k), 32'(W + 1));
    check_result(1'b0, 8'd99, 8'd10);

    // R9: results held while inputs wander
    q_hold = quotient; r_hold = remainder;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dividend = 8'($urandom); divisor = 8'd0; signed_op = ~signed_op;
    end
    check("R9 quotient held", 32'(quotient), 32'(q_hold));
    check("R9 remainder held", 32'(remainder), 32'(r_hold));
    check("R9 flag held", 32'(div_by_zero), 32'd0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] a, b;
      bit s;
      s = 1'($urandom);
      a = 8'($urandom);
      b = (($urandom % 8) == 0) ? 8'd0 : 8'($urandom);
      if (($urandom % 4) == 0) b = 8'($urandom % 4);
      run_op(s, a, b);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule